// File: doc/BRIEF.md
# Serial Device Identifier Reader

This block fetches a 57-bit unique device identifier from an on-chip serial identifier source and makes it readable by a processor over a read-only AXI4-Lite slave port. Once reset is released, a three-state controller issues a start cycle to the source. The start cycle raises both the load and shift controls. The controller then keeps only the shift control high while it captures one serial bit per clock into a 64-bit holding register. The first bit to arrive goes to bit 0. After the last bit is captured, a completion flag rises and stays high until the next reset.

Software reads the identifier as two 32-bit words and polls a status word for completion. Writes on the AXI4-Lite port complete normally with an OKAY response, but their data has no effect. The serial source is modelled as a generic port with load, shift and data-out signals. A load at a clock edge makes bit 0 appear on data-out, and each later edge with shift high presents the next bit.

Top module: `serial_id_reader`

## Requirements
- R1: While reset is low, `id_load` and `id_shift` are both 0. In the first cycle after reset is released, both are 1. `id_load` is high for that single cycle only.
- R2: After the start cycle, `id_shift` stays 1 and `id_load` stays 0 for exactly 57 cycles, and then `id_shift` drops to 0.
- R3: The bit on `id_dout` at the k-th capture edge (k = 0..56, where the first capture edge is the one after the start cycle) is stored as identifier bit k. Holding-register bits 63:57 are 0.
- R4: `id_done` rises 58 clock edges after the first edge at which reset is high. It then stays 1 with both controls at 0 until the next reset.
- R5: A read of offset 0x00 returns identifier bits 31:0.
- R6: A read of offset 0x04 returns identifier bits 56:32 in data bits 24:0, with data bits 31:25 equal to 0.
- R7: A read of offset 0x08 returns `id_done` in data bit 0 and 0 in all other bits. The word is 0 while capture is still running.
- R8: A read of the unmapped offset 0x0C returns 0 with an OKAY response.
- R9: The read address is accepted on an edge where ARVALID and ARREADY are both 1. RVALID is 1 from the next cycle, and RVALID and RDATA hold steady until an edge with RREADY high. ARREADY is 0 while a response is pending.
- R10: RRESP is always 2'b00 (OKAY).
- R11: A write completes with BVALID one cycle after its address and data are accepted, with BRESP = 2'b00. BVALID is held until BREADY. The identifier words read back unchanged afterwards.
- R12: A reset clears the identifier and `id_done`, drops RVALID and BVALID, and is followed by a fresh read of the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_load | output | 1 | Load control to the serial identifier source |
| id_shift | output | 1 | Shift control to the serial identifier source |
| id_dout | input | 1 | Serial data from the identifier source |
| id_done | output | 1 | Capture complete |
| s_awaddr | input | 4 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data (ignored) |
| s_wstrb | input | 4 | Write strobes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The start controls follow the release of reset in the same cycle. The completion flag is due 58 edges later. The bench counts negative edges from the release and samples the controls and the flag one nanosecond after each negative edge. RVALID and BVALID are due one edge after their request is accepted, so the driver samples the readies just before the accepting edge and checks the valid flags at the following negative edge. The scoreboard monitor compares each read word just before the edge that completes the handshake, so it sees exactly the data the master would take.

// File: rtl/sid_pkg.sv
`timescale 1ns/1ps
// Package sid_pkg
// Shared state encoding, register word indices and response code for the
// serial identifier reader. Assumes 32-bit words on a byte-addressed bus.
package sid_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_READ  = 2'd1,
        ST_DONE  = 2'd2
    } sid_state_e;

    localparam int WORD_ID_LO  = 0;   // byte offset 0x00
    localparam int WORD_ID_HI  = 1;   // byte offset 0x04
    localparam int WORD_STATUS = 2;   // byte offset 0x08

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/sid_ctrl.sv
`timescale 1ns/1ps
// Module sid_ctrl
// Sequences the serial identifier source. The first cycle after reset
// drives load and shift together. The next ID_BITS cycles drive shift alone
// and enable capture, and the controller then parks in the done state.
// Assumes the source presents bit 0 after the edge that samples load, and
// the next bit after each later edge with shift high.
module sid_ctrl
    import sid_pkg::*;
#(
    parameter int ID_BITS = 57
) (
    input  logic clk,
    input  logic rst_n,
    output logic src_load,
    output logic src_shift,
    output logic cap_en,
    output logic done
);

    localparam int CNT_W = $clog2(ID_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ID_BITS - 1);

    sid_state_e       state;
    logic [CNT_W-1:0] bit_cnt;

    // State and captured-bit counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_RESET;
            bit_cnt <= '0;
        end else begin
            case (state)
                ST_RESET: begin
                    state   <= ST_READ;
                    bit_cnt <= '0;
                end
                ST_READ: begin
                    if (bit_cnt == LAST_BIT) begin
                        state <= ST_DONE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    // Source controls, quiet while reset is held.
    always_comb begin
        src_load  = rst_n && (state == ST_RESET);
        src_shift = rst_n && ((state == ST_RESET) || (state == ST_READ));
        cap_en    = (state == ST_READ);
        done      = (state == ST_DONE);
    end

endmodule

// File: rtl/sid_capture.sv
`timescale 1ns/1ps
// Module sid_capture
// Assembles the serial identifier into the holding register. Each captured
// bit enters at the top of an ID_BITS-wide shift register and moves down,
// so after ID_BITS captures the first bit sits at bit 0. Holding bits above
// ID_BITS read as zero. Assumes HOLD_W >= ID_BITS.
module sid_capture #(
    parameter int ID_BITS = 57,
    parameter int HOLD_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              serial_in,
    output logic [HOLD_W-1:0] id_value
);

    localparam int PAD_W = HOLD_W - ID_BITS;

    logic [ID_BITS-1:0] shreg;

    // Shift one serial bit in per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (cap_en) begin
            shreg <= {serial_in, shreg[ID_BITS-1:1]};
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign id_value = {{PAD_W{1'b0}}, shreg};
        end else begin : g_nopad
            assign id_value = shreg;
        end
    endgenerate

endmodule

// File: rtl/sid_axil_rd.sv
`timescale 1ns/1ps
// Module sid_axil_rd
// AXI4-Lite read channel. Decodes the word index, snapshots the selected
// word when the address is accepted, and holds it with RVALID until RREADY.
// One response at a time: ARREADY is low while a response is pending.
// Assumes ADDR_W >= 4 and HOLD_W - DATA_W <= DATA_W.
module sid_axil_rd
    import sid_pkg::*;
#(
    parameter int HOLD_W = 64,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic [HOLD_W-1:0] id_value,
    input  logic              done
);

    localparam int WIDX_W = ADDR_W - 2;
    localparam int HI_W   = HOLD_W - DATA_W;
    localparam logic [WIDX_W-1:0] IDX_LO   = WIDX_W'(WORD_ID_LO);
    localparam logic [WIDX_W-1:0] IDX_HI   = WIDX_W'(WORD_ID_HI);
    localparam logic [WIDX_W-1:0] IDX_STAT = WIDX_W'(WORD_STATUS);

    logic [WIDX_W-1:0] widx;
    logic [DATA_W-1:0] hi_word;
    logic [DATA_W-1:0] rdata_sel;
    logic              unused_addr_lsb;

    assign widx            = araddr[ADDR_W-1:2];
    assign unused_addr_lsb = ^araddr[1:0];

    generate
        if (HI_W == DATA_W) begin : g_hi_full
            assign hi_word = id_value[HOLD_W-1:DATA_W];
        end else begin : g_hi_pad
            assign hi_word = {{(DATA_W-HI_W){1'b0}}, id_value[HOLD_W-1:DATA_W]};
        end
    endgenerate

    // Word select by index; unmapped indices read zero.
    always_comb begin
        case (widx)
            IDX_LO:   rdata_sel = id_value[DATA_W-1:0];
            IDX_HI:   rdata_sel = hi_word;
            IDX_STAT: rdata_sel = {{(DATA_W-1){1'b0}}, done};
            default:  rdata_sel = '0;
        endcase
    end

    assign arready = !rvalid;
    assign rresp   = RESP_OKAY;

    // Response register: load on accept, release on RREADY.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= rdata_sel;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/sid_axil_wr.sv
`timescale 1ns/1ps
// Module sid_axil_wr
// AXI4-Lite write channel that acknowledges and discards writes. Address
// and data may arrive in either order; once both have been taken, a single
// OKAY response is raised and held until BREADY. No new write is accepted
// while that response is pending.
module sid_axil_wr
    import sid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       awvalid,
    output logic       awready,
    input  logic       wvalid,
    output logic       wready,
    output logic [1:0] bresp,
    output logic       bvalid,
    input  logic       bready
);

    logic aw_held;
    logic w_held;
    logic aw_next;
    logic w_next;

    assign awready = !aw_held && !bvalid;
    assign wready  = !w_held && !bvalid;
    assign aw_next = aw_held || (awvalid && awready);
    assign w_next  = w_held || (wvalid && wready);
    assign bresp   = RESP_OKAY;

    // Track accepted halves and raise or drop the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
            bvalid  <= 1'b0;
        end else if (bvalid) begin
            if (bready) begin
                bvalid <= 1'b0;
            end
        end else if (aw_next && w_next) begin
            bvalid  <= 1'b1;
            aw_held <= 1'b0;
            w_held  <= 1'b0;
        end else begin
            aw_held <= aw_next;
            w_held  <= w_next;
        end
    end

endmodule

// File: rtl/serial_id_reader.sv
`timescale 1ns/1ps
// Module serial_id_reader
// Top level: reads a serial device identifier after reset and exposes it
// over a read-only AXI4-Lite slave. Word 0 holds identifier bits 31:0,
// word 1 the remaining bits, word 2 the completion flag. Writes are
// acknowledged and ignored. Assumes a single clock and synchronous reset.
module serial_id_reader #(
    parameter int ID_BITS = 57,
    parameter int HOLD_W  = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                id_load,
    output logic                id_shift,
    input  logic                id_dout,
    output logic                id_done,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready
);

    logic              cap_en;
    logic [HOLD_W-1:0] id_value;
    logic              unused_wr_payload;

    assign unused_wr_payload = ^{s_awaddr, s_wdata, s_wstrb};

    sid_ctrl #(.ID_BITS(ID_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_load  (id_load),
        .src_shift (id_shift),
        .cap_en    (cap_en),
        .done      (id_done)
    );

    sid_capture #(.ID_BITS(ID_BITS), .HOLD_W(HOLD_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .serial_in (id_dout),
        .id_value  (id_value)
    );

    sid_axil_rd #(.HOLD_W(HOLD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .araddr   (s_araddr),
        .arvalid  (s_arvalid),
        .arready  (s_arready),
        .rdata    (s_rdata),
        .rresp    (s_rresp),
        .rvalid   (s_rvalid),
        .rready   (s_rready),
        .id_value (id_value),
        .done     (id_done)
    );

    sid_axil_wr u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bresp   (s_bresp),
        .bvalid  (s_bvalid),
        .bready  (s_bready)
    );

endmodule

// File: rtl/sid_checker.sv
`timescale 1ns/1ps
// Module sid_checker
// Protocol and sequencing properties for serial_id_reader, attached by bind.
// Observes top-level ports only.
module sid_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              id_load,
    input logic              id_shift,
    input logic              id_done,
    input logic              s_arready,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [DATA_W-1:0] s_rdata,
    input logic              s_bvalid,
    input logic              s_bready
);

    a_r1_load_with_shift: assert property (@(posedge clk) disable iff (!rst_n)
        id_load |-> id_shift);

    a_r1_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        id_load |=> !id_load);

    a_r2_shift_ends_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_shift) |-> id_done);

    a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        id_done |=> id_done);

    a_r4_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        id_done |-> (!id_load && !id_shift));

    a_r9_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> !s_arready);

    a_r11_hold_bvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

endmodule

bind serial_id_reader sid_checker #(.DATA_W(DATA_W)) u_sid_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_load   (id_load),
    .id_shift  (id_shift),
    .id_done   (id_done),
    .s_arready (s_arready),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .s_rdata   (s_rdata),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready)
);

// File: tb/serial_id_reader_test.sv
`timescale 1ns/1ps
// Scoreboard bench for serial_id_reader: a behavioural identifier source,
// a read driver that queues expected words and a monitor that checks them.
module serial_id_reader_test;

    localparam int ID_BITS = 57;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst_n = 1'b0;
    logic                id_load, id_shift, id_dout, id_done;
    logic [ADDR_W-1:0]   s_awaddr = '0;
    logic                s_awvalid = 1'b0;
    logic                s_awready;
    logic [DATA_W-1:0]   s_wdata = '0;
    logic [DATA_W/8-1:0] s_wstrb = '0;
    logic                s_wvalid = 1'b0;
    logic                s_wready;
    logic [1:0]          s_bresp;
    logic                s_bvalid;
    logic                s_bready = 1'b0;
    logic [ADDR_W-1:0]   s_araddr = '0;
    logic                s_arvalid = 1'b0;
    logic                s_arready;
    logic [DATA_W-1:0]   s_rdata;
    logic [1:0]          s_rresp;
    logic                s_rvalid;
    logic                s_rready = 1'b1;

    serial_id_reader uut (
        .clk(clk), .rst_n(rst_n),
        .id_load(id_load), .id_shift(id_shift), .id_dout(id_dout), .id_done(id_done),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
    );

    // Identifier source model: load presents bit 0, shift presents the next.
    logic [ID_BITS-1:0] tb_id  = '0;
    logic [ID_BITS-1:0] src_sr = '0;
    always @(posedge clk) begin
        if (id_load)       src_sr <= tb_id;
        else if (id_shift) src_sr <= {1'b0, src_sr[ID_BITS-1:1]};
    end
    assign id_dout = src_sr[0];

    int n_checks = 0;
    int n_fail   = 0;
    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];

    task automatic check_eq(input string req, input logic [DATA_W-1:0] act,
                            input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Monitor: compare each completed read just before its handshake edge.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (s_rvalid && s_rready) begin
                if (exp_q.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R9 unexpected response: actual %h expected none", s_rdata);
                end else begin
                    logic [DATA_W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check_eq(t, s_rdata, e);
                    check_eq("R10 rresp okay", {30'b0, s_rresp}, '0);
                end
            end
        end
    end

    // Read driver: queue the expected word, issue the address, check latency.
    task automatic axi_read(input logic [ADDR_W-1:0] addr,
                            input logic [DATA_W-1:0] exp, input string tag);
        bit acc;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        s_araddr  = addr;
        s_arvalid = 1'b1;
        do begin
            #5;
            acc = s_arready;
            @(negedge clk);
        end while (!acc);
        s_arvalid = 1'b0;
        check_eq("R9 rvalid one cycle after accept", {31'b0, s_rvalid}, 32'd1);
    endtask

    task automatic wait_resp_done();
        while (s_rvalid) @(negedge clk);
    endtask

    // Write driver: address and data together, response under back-pressure.
    task automatic axi_write(input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] data);
        bit acc;
        @(negedge clk);
        s_awaddr = addr; s_awvalid = 1'b1;
        s_wdata  = data; s_wvalid  = 1'b1; s_wstrb = '1;
        s_bready = 1'b0;
        do begin
            #5;
            acc = s_awready && s_wready;
            @(negedge clk);
        end while (!acc);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        check_eq("R11 bvalid after write", {31'b0, s_bvalid}, 32'd1);
        check_eq("R11 bresp okay", {30'b0, s_bresp}, '0);
        repeat (2) begin
            @(negedge clk);
            check_eq("R11 bvalid held", {31'b0, s_bvalid}, 32'd1);
        end
        s_bready = 1'b1;
        @(negedge clk);
        check_eq("R11 bvalid released", {31'b0, s_bvalid}, '0);
        s_bready = 1'b0;
    endtask

    // Reset, then follow the capture either cycle by cycle or via status.
    task automatic run_capture(input logic [ID_BITS-1:0] id, input bit seq_checks);
        int shifts;
        int loads;
        tb_id = id;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R12 done low in reset", {31'b0, id_done}, '0);
        check_eq("R1 controls low in reset", {30'b0, id_load, id_shift}, '0);
        check_eq("R12 rvalid/bvalid low in reset", {30'b0, s_rvalid, s_bvalid}, '0);
        rst_n = 1'b1;
        #1;
        check_eq("R1 start cycle load+shift", {30'b0, id_load, id_shift}, 32'd3);
        if (seq_checks) begin
            shifts = 0;
            loads  = 0;
            for (int n = 1; n <= 58; n++) begin
                @(negedge clk);
                #1;
                if (id_shift && !id_load) shifts++;
                if (id_load) loads++;
                if (n == 57) check_eq("R4 done not before edge 58", {31'b0, id_done}, '0);
                if (n == 58) begin
                    check_eq("R4 done at edge 58", {31'b0, id_done}, 32'd1);
                    check_eq("R4 controls off at done", {30'b0, id_load, id_shift}, '0);
                end
            end
            check_eq("R2 shift-only cycles", shifts, 32'd57);
            check_eq("R1 load single cycle", loads, '0);
        end else begin
            int guard;
            axi_read(4'h8, 32'd0, "R7 status before done");
            wait_resp_done();
            guard = 0;
            while (!id_done && guard < 200) begin
                @(negedge clk);
                guard++;
            end
        end
        repeat (4) begin
            @(negedge clk);
            check_eq("R4 done sticky", {31'b0, id_done}, 32'd1);
        end
    endtask

    localparam logic [ID_BITS-1:0] ID_A = 57'h1_3C5A_96E7_0F2D_B8;
    localparam logic [ID_BITS-1:0] ID_B = 57'h1_0000_0000_0000_01;
    localparam logic [ID_BITS-1:0] ID_C = '1;

    initial begin
        logic [DATA_W-1:0] hold_exp;
        // Run A: full sequence and all offsets.
        run_capture(ID_A, 1'b1);
        axi_read(4'h0, ID_A[31:0], "R5 low word");            wait_resp_done();
        axi_read(4'h4, {7'b0, ID_A[56:32]}, "R6 high word");  wait_resp_done();
        axi_read(4'h8, 32'd1, "R7 status done");              wait_resp_done();
        axi_read(4'hC, 32'd0, "R8 unmapped reads zero");      wait_resp_done();

        // Back-pressure: response must hold until RREADY.
        hold_exp = {7'b0, ID_A[56:32]};
        s_rready = 1'b0;
        axi_read(4'h4, hold_exp, "R9 held word delivered");
        repeat (3) begin
            @(negedge clk);
            check_eq("R9 rvalid held", {31'b0, s_rvalid}, 32'd1);
            check_eq("R9 rdata stable", s_rdata, hold_exp);
            check_eq("R9 arready low while pending", {31'b0, s_arready}, '0);
        end
        s_rready = 1'b1;
        wait_resp_done();

        // Writes are acknowledged and ignored.
        axi_write(4'h0, 32'hFFFF_FFFF);
        axi_write(4'h4, 32'h0000_0000);
        axi_read(4'h0, ID_A[31:0], "R11 low word unchanged");         wait_resp_done();
        axi_read(4'h4, {7'b0, ID_A[56:32]}, "R11 high word unchanged"); wait_resp_done();

        // Run B: edge bits, status polled during capture.
        run_capture(ID_B, 1'b0);
        axi_read(4'h0, 32'h0000_0001, "R3 bit 0 first in");  wait_resp_done();
        axi_read(4'h4, 32'h0100_0000, "R3 bit 56 last in");  wait_resp_done();

        // Run C: all ones, upper bits of high word stay zero.
        run_capture(ID_C, 1'b1);
        axi_read(4'h0, 32'hFFFF_FFFF, "R12 fresh low word after reset"); wait_resp_done();
        axi_read(4'h4, 32'h01FF_FFFF, "R6 high word padding zero");      wait_resp_done();

        repeat (3) @(negedge clk);
        check_eq("R9 all responses seen", exp_q.size(), '0);
        report();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule